// File: doc/BRIEF.md
# Audio InfoFrame Packet Builder

This block keeps one audio InfoFrame for a display transmitter: three fixed header bytes, ten data bytes and a checksum that the hardware works out itself. Software writes the data bytes and a small control register through a plain write port and can read every byte back through a read port. When the packet scheduler raises `send_req`, the block takes a private copy of the packet and streams its fourteen bytes out on a valid/ready byte interface.

Software can write the speaker-allocation byte (data byte 4) with any value, but the block stores it as 0x13, the eight-channel code, whenever that value is nonzero. Data bytes 6 to 10 are always zero, whatever is written to them. The control register has an enable bit and a repeat bit:
- With repeat set, the packet goes out on every request while enable stays set.
- Without repeat, the packet goes out once and enable then clears itself.

The serializer is a three-state machine:
- ST_IDLE waits for a request. It moves to ST_HEAD on `send_req` with enable set, and takes the snapshot in that same cycle. It ignores the request when enable is clear.
- ST_HEAD sends the type, version, length and checksum bytes. It moves to ST_BODY when the checksum byte is accepted.
- ST_BODY sends data bytes 1 to 10. It returns to ST_IDLE when the tenth byte is accepted.

Top module: `aif_packet_builder`

## Requirements
- R1: After reset the serializer is idle with `pkt_valid` low. Every data byte and the control register read 0, and the checksum reads 0x71.
- R2: Register map. Addresses 0 to 9 hold data bytes 1 to 10. Address 10 is control, with enable at bit 5 and repeat at bit 4. Address 11 reads the checksum. Addresses 12, 13 and 14 read the header bytes 0x84, 0x01 and 0x0A. Any other address reads 0.
- R3: A write of a nonzero value to address 3 (data byte 4) stores 0x13. A write of zero stores 0x00.
- R4: Writes to addresses 5 to 9 have no effect. Those bytes read back as zero and go out as zero.
- R5: The checksum is (0x100 minus the 8-bit sum of the three header bytes and the ten data bytes) modulo 256. It follows every write in the cycle after that write.
- R6: A packet has 14 bytes in this order: type, version, length, checksum, then data bytes 1 to 10. `pkt_last` is high only with the 14th byte, and `pkt_valid` falls in the cycle after that byte is accepted.
- R7: A byte advances only on a cycle with both `pkt_valid` and `pkt_ready` high. While `pkt_ready` is low, `pkt_valid` and `pkt_data` hold.
- R8: `send_req` is ignored when enable is clear, and also while a packet is in progress.
- R9: With repeat set, enable stays set after a packet. With repeat clear, enable reads 0 from the cycle after the last byte is accepted.
- R10: A packet carries the register contents from the cycle its request was taken. A data write in that same cycle, or during the packet, shows up only from the next packet.
- R11: A software write to the control register in the cycle the last byte is accepted takes priority over the self-clear of enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| send_req | input | 1 | Transmit slot request from the packet scheduler |
| pkt_valid | output | 1 | Packet byte valid |
| pkt_ready | input | 1 | Downstream accepts the byte |
| pkt_data | output | 8 | Packet byte |
| pkt_last | output | 1 | Marks the final byte of the packet |

## Verification
Two pairs of functions can land on the same clock edge.

The first pair is a data-register write and the taking of a request. The bench drives a write to data byte 2 in the cycle it raises `send_req`, and a write to data byte 1 in the middle of a stalled packet. It then judges each streamed packet against a snapshot of the reference model taken before the write, and the following packet against the updated model.

The second pair is the self-clear of enable and a software control write. The bench forces acceptance of the last byte while it writes the control register with enable set. It then expects enable to read 1, where a packet without that write must read 0.

// File: rtl/aif_pkg.sv
package aif_pkg;
    localparam int ADDR_W      = 4;
    localparam int BYTE_W      = 8;
    localparam int NUM_DB      = 10;
    localparam int STORED_DB   = 5;
    localparam int CA_IDX      = 3;
    localparam int HDR_BYTES   = 3;
    localparam int PKT_LEN     = HDR_BYTES + 1 + NUM_DB;
    localparam int IDX_W       = $clog2(PKT_LEN);
    localparam int ADDR_CTRL   = NUM_DB;
    localparam int ADDR_CHK    = NUM_DB + 1;
    localparam int ADDR_HDR    = NUM_DB + 2;
    localparam int EN_BIT      = 5;
    localparam int REP_BIT     = 4;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t HDR_TYPE = 8'h84;
    localparam byte_t HDR_VER  = 8'h01;
    localparam byte_t HDR_LEN  = 8'h0A;
    localparam byte_t CA_CODE  = 8'h13;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HEAD,
        ST_BODY
    } ser_state_e;

    function automatic byte_t hdr_byte(input int i);
        case (i)
            0:       return HDR_TYPE;
            1:       return HDR_VER;
            default: return HDR_LEN;
        endcase
    endfunction
endpackage

// File: rtl/aif_regs.sv
module aif_regs
    import aif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  byte_t             wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              clr_en,
    output byte_t             rd_data,
    output byte_t             db_o [STORED_DB],
    output byte_t             chk_o,
    output logic              en_o,
    output logic              rep_o
);
    logic  ctrl_wr;
    byte_t acc;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));

    for (genvar g = 0; g < STORED_DB; g++) begin : g_db
        byte_t q;
        if (g == CA_IDX) begin : g_ca
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_en && wr_addr == ADDR_W'(g))
                    q <= (wr_data != '0) ? CA_CODE : '0;
            end
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_en && wr_addr == ADDR_W'(g))
                    q <= wr_data;
            end
        end
        assign db_o[g] = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o  <= 1'b0;
            rep_o <= 1'b0;
        end else if (ctrl_wr) begin
            en_o  <= wr_data[EN_BIT];
            rep_o <= wr_data[REP_BIT];
        end else if (clr_en) begin
            en_o  <= 1'b0;
        end
    end

    always_comb begin
        acc = HDR_TYPE + HDR_VER + HDR_LEN;
        for (int i = 0; i < STORED_DB; i++)
            acc = acc + db_o[i];
        chk_o = ~acc + 8'd1;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < STORED_DB; i++)
            if (rd_addr == ADDR_W'(i))
                rd_data = db_o[i];
        for (int i = 0; i < HDR_BYTES; i++)
            if (rd_addr == ADDR_W'(ADDR_HDR + i))
                rd_data = hdr_byte(i);
        if (rd_addr == ADDR_W'(ADDR_CHK))
            rd_data = chk_o;
        if (rd_addr == ADDR_W'(ADDR_CTRL)) begin
            rd_data[EN_BIT]  = en_o;
            rd_data[REP_BIT] = rep_o;
        end
    end

    // R3
    ca_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(CA_IDX) && wr_data != '0) |=> (db_o[CA_IDX] == CA_CODE));

    // R9
    self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !ctrl_wr) |=> !en_o);

    // R11
    sw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && ctrl_wr && wr_data[EN_BIT]) |=> en_o);
endmodule

// File: rtl/aif_serializer.sv
module aif_serializer
    import aif_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  send_req,
    input  logic  en,
    input  byte_t db_i [STORED_DB],
    input  byte_t chk_i,
    input  logic  pkt_ready,
    output logic  pkt_valid,
    output byte_t pkt_data,
    output logic  pkt_last,
    output logic  pkt_done
);
    ser_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    byte_t             sh_db [STORED_DB];
    byte_t             sh_chk;
    logic              start, accept;

    assign start  = (state_q == ST_IDLE) && send_req && en;
    assign accept = (state_q != ST_IDLE) && pkt_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_HEAD;
            ST_HEAD: if (accept && idx_q == IDX_W'(HDR_BYTES)) state_d = ST_BODY;
            ST_BODY: if (accept && idx_q == IDX_W'(PKT_LEN - 1)) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start)
                idx_q <= '0;
            else if (accept)
                idx_q <= idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_chk <= '0;
            for (int i = 0; i < STORED_DB; i++) sh_db[i] <= '0;
        end else if (start) begin
            sh_chk <= chk_i;
            for (int i = 0; i < STORED_DB; i++) sh_db[i] <= db_i[i];
        end
    end

    always_comb begin
        pkt_valid = (state_q != ST_IDLE);
        pkt_last  = pkt_valid && (idx_q == IDX_W'(PKT_LEN - 1));
        pkt_done  = pkt_last && pkt_ready;
        pkt_data  = '0;
        if (pkt_valid) begin
            for (int i = 0; i < HDR_BYTES; i++)
                if (idx_q == IDX_W'(i)) pkt_data = hdr_byte(i);
            if (idx_q == IDX_W'(HDR_BYTES)) pkt_data = sh_chk;
            for (int k = 0; k < STORED_DB; k++)
                if (idx_q == IDX_W'(HDR_BYTES + 1 + k)) pkt_data = sh_db[k];
        end
    end

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data)));

    // R8
    idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_valid && send_req && !en) |=> !pkt_valid);

    // R6
    first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_valid) |-> (pkt_data == HDR_TYPE));

    // R6
    end_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_valid);
endmodule

// File: rtl/aif_packet_builder.sv
module aif_packet_builder
    import aif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              send_req,
    output logic              pkt_valid,
    input  logic              pkt_ready,
    output logic [7:0]        pkt_data,
    output logic              pkt_last
);
    byte_t db   [STORED_DB];
    byte_t chk;
    logic  en, rep, done, clr_en;

    assign clr_en = done && !rep;

    aif_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .clr_en  (clr_en),
        .rd_data (rd_data),
        .db_o    (db),
        .chk_o   (chk),
        .en_o    (en),
        .rep_o   (rep)
    );

    aif_serializer u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .send_req  (send_req),
        .en        (en),
        .db_i      (db),
        .chk_i     (chk),
        .pkt_ready (pkt_ready),
        .pkt_valid (pkt_valid),
        .pkt_data  (pkt_data),
        .pkt_last  (pkt_last),
        .pkt_done  (done)
    );
endmodule

// File: tb/tb_aif_packet_builder.sv
module tb_aif_packet_builder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       send_req = 1'b0;
    logic       pkt_valid;
    logic       pkt_ready = 1'b0;
    logic [7:0] pkt_data;
    logic       pkt_last;

    always #2 clk = ~clk;

    aif_packet_builder dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .send_req(send_req), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .pkt_data(pkt_data), .pkt_last(pkt_last)
    );

    int         n_chk = 0;
    int         n_bad = 0;
    bit         finished = 1'b0;
    logic [7:0] m_db [10];
    bit         m_en, m_rep;
    logic [7:0] exp_pkt [14];

    function automatic logic [7:0] ref_chk();
        logic [7:0] s;
        s = 8'h84 + 8'h01 + 8'h0A;
        for (int i = 0; i < 10; i++) s = s + m_db[i];
        return 8'h00 - s;
    endfunction

    function automatic logic [7:0] ref_ctrl();
        return {2'b00, m_en, m_rep, 4'b0000};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic model_write(input int a, input logic [7:0] d);
        if (a == 3)      m_db[3] = (d != 8'h00) ? 8'h13 : 8'h00;
        else if (a < 5)  m_db[a] = d;
        else if (a == 10) begin m_en = d[5]; m_rep = d[4]; end
    endtask

    task automatic do_write(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        model_write(a, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_chk(input int a, input logic [7:0] exp, input string req);
        rd_addr = 4'(a);
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic build_exp();
        exp_pkt[0] = 8'h84; exp_pkt[1] = 8'h01; exp_pkt[2] = 8'h0A;
        exp_pkt[3] = ref_chk();
        for (int i = 0; i < 10; i++) exp_pkt[4+i] = m_db[i];
    endtask

    task automatic run_pkt(input int stall, input bit start_wr, input bit mid_wr,
                           input bit mid_req, input bit last_wr, input string req);
        int k = 0;
        int guard = 0;
        bit hold = 1'b0;
        bit sw_ctrl = 1'b0;
        logic [7:0] prev = '0;
        @(negedge clk);
        build_exp();
        send_req = 1'b1;
        if (start_wr) begin
            wr_en = 1'b1; wr_addr = 4'd1; wr_data = 8'h5A;
            model_write(1, 8'h5A);
        end
        @(negedge clk);
        send_req = 1'b0; wr_en = 1'b0;
        while (k < 14 && guard < 1000) begin
            guard++;
            if (!pkt_valid) check({req, " valid"}, {7'd0, pkt_valid}, 8'h01);
            if (hold) check("R7 hold", pkt_data, prev);
            pkt_ready = (($urandom % 100) >= 32'(stall));
            if (last_wr && k == 13) pkt_ready = 1'b1;
            if (mid_req && k == 6) send_req = 1'b1;
            if (mid_wr && k == 7) begin
                wr_en = 1'b1; wr_addr = 4'd0; wr_data = ~m_db[0];
                model_write(0, ~m_db[0]);
            end
            if (last_wr && k == 13) begin
                wr_en = 1'b1; wr_addr = 4'd10; wr_data = 8'h20;
                model_write(10, 8'h20);
                sw_ctrl = 1'b1;
            end
            if (pkt_ready) begin
                check(req, pkt_data, exp_pkt[k]);
                if (k == 13) check("R6 last", {7'd0, pkt_last}, 8'h01);
                else if (pkt_last) check("R6 last early", {7'd0, pkt_last}, 8'h00);
                k++;
                hold = 1'b0;
            end else begin
                prev = pkt_data;
                hold = 1'b1;
            end
            @(negedge clk);
            send_req = 1'b0; wr_en = 1'b0; pkt_ready = 1'b0;
        end
        if (k < 14) check({req, " incomplete"}, 8'(k), 8'd14);
        if (!m_rep && !sw_ctrl) m_en = 1'b0;
        check("R6 valid drop", {7'd0, pkt_valid}, 8'h00);
        read_chk(10, ref_ctrl(), sw_ctrl ? "R11 ctrl" : "R9 ctrl");
        if (mid_req) begin
            for (int c = 0; c < 3; c++) begin
                @(negedge clk);
                check("R8 busy ignore", {7'd0, pkt_valid}, 8'h00);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 10; i++) m_db[i] = 8'h00;
        m_en = 1'b0; m_rep = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2: reset state and map
        check("R1 valid", {7'd0, pkt_valid}, 8'h00);
        for (int a = 0; a < 11; a++) read_chk(a, 8'h00, "R1 reset byte");
        read_chk(11, 8'h71, "R1 checksum");
        read_chk(12, 8'h84, "R2 type");
        read_chk(13, 8'h01, "R2 version");
        read_chk(14, 8'h0A, "R2 length");
        read_chk(15, 8'h00, "R2 unmapped");

        // R3 allocation override
        do_write(0, 8'h11); do_write(1, 8'h22); do_write(2, 8'h33);
        do_write(3, 8'h44); do_write(4, 8'h55);
        read_chk(3, 8'h13, "R3 nonzero");
        read_chk(11, ref_chk(), "R5 checksum");
        do_write(3, 8'h00);
        read_chk(3, 8'h00, "R3 zero");
        read_chk(11, ref_chk(), "R5 checksum");
        do_write(3, 8'h80);
        read_chk(3, 8'h13, "R3 msb only");

        // R4 upper bytes ignored
        for (int a = 5; a < 10; a++) do_write(a, 8'hFF);
        for (int a = 5; a < 10; a++) read_chk(a, 8'h00, "R4 ignored");
        read_chk(11, ref_chk(), "R5 checksum");

        // R6 / R9 once mode
        do_write(10, 8'h20);
        run_pkt(0, 0, 0, 0, 0, "R6 order");
        // R8 disabled
        @(negedge clk); send_req = 1'b1;
        @(negedge clk); send_req = 1'b0;
        for (int c = 0; c < 3; c++) begin
            check("R8 disabled", {7'd0, pkt_valid}, 8'h00);
            @(negedge clk);
        end

        // R7 / R8 / R9 repeat mode with stalls and a request mid-packet
        do_write(10, 8'h30);
        run_pkt(50, 0, 0, 1, 0, "R7 stalled");
        run_pkt(20, 0, 0, 0, 0, "R9 repeat");

        // R10 writes at start and mid-packet
        run_pkt(30, 1, 0, 0, 0, "R10 start write");
        run_pkt(0, 0, 0, 0, 0, "R10 next packet");
        run_pkt(40, 0, 1, 0, 0, "R10 mid write");
        read_chk(11, ref_chk(), "R5 after mid write");
        run_pkt(0, 0, 0, 0, 0, "R10 next packet");

        // R11 collision of self-clear and control write
        do_write(10, 8'h20);
        run_pkt(25, 0, 0, 0, 1, "R11 packet");
        run_pkt(0, 0, 0, 0, 0, "R9 once again");

        // random mix
        for (int it = 0; it < 25; it++) begin
            for (int w = 0; w < 4; w++) begin
                int a;
                logic [7:0] d;
                a = int'($urandom % 10);
                d = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
                do_write(a, d);
                read_chk(a, m_db[a], "R3 R4 readback");
            end
            read_chk(11, ref_chk(), "R5 random");
            do_write(10, ($urandom % 2 == 0) ? 8'h30 : 8'h20);
            run_pkt(int'($urandom % 60), 1'($urandom), 1'($urandom), m_rep, 0, "R6 random");
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule